// File: doc/BRIEF.md
# Flash Command Sequencer with Status Polling

This block models the write-command state machine of a byte-wide flash memory. It watches bus write cycles (address, data and write enable) and recognises command sequences that begin with a two-write unlock prefix. The recognised operations are byte program, sector erase, chip erase, and entry to and exit from an identification mode. A recognised program or erase starts a timed embedded operation against an internal byte array. The operation's length is a parameter given in clock cycles.

Reads are registered. While an embedded operation runs, a read returns a status byte and not array data. Bit 7 is a data-polling bit and bit 6 flips on every read. When the operation ends, the block goes back to array reads by itself. A single `permit` input carries the protection decision, which is made outside the block. If `permit` is low on the final write of a sequence, the operation never starts.

Top module: `flash_cmd_seq`

## Requirements
- R1: During and after synchronous reset, `busy` is 0 and `rdata` is 00h. Every array byte reads FFh.
- R2: The unlock prefix is AAh written at address 5555h, then 55h written at 2AAAh. A third write at 5555h carries the command: A0h program, 80h erase setup, 90h ID entry, F0h exit. A command byte at any other address is not accepted as a command.
- R3: Byte program takes four writes: the prefix, A0h, then the target address with the data. When the operation completes, the stored byte becomes old AND new. Programming can clear bits but never set them.
- R4: Sector erase takes six writes: the prefix, 80h, the prefix again, then 30h at any address inside the target sector. A sector is 2^SEC_AW bytes. Only that sector returns to FFh.
- R5: Chip erase takes the same five leading writes followed by 10h at 5555h. The whole array returns to FFh.
- R6: During a program operation, read bit 7 is the complement of bit 7 of the byte being programmed. After completion the same address returns the true stored data.
- R7: During an erase operation, read bit 7 is 0 and read bits 5..0 are 0.
- R8: During any embedded operation, bit 6 of each successive read is the inverse of the previous busy read. After reset, the first busy read returns 0.
- R9: `busy` rises on the edge that accepts the final write. It stays high for exactly T_PROG, T_SECT or T_CHIP cycles, then falls, and reads return array data again with no host action.
- R10: Write 90h after the prefix to enter ID mode. In ID mode, a read at address 0 returns DAh, address 1 returns B0h, and any other address returns 00h. Any F0h write (alone or after the prefix) leaves ID mode. F0h written as program data is the exception.
- R11: A write that does not fit the expected sequence returns the sequencer to its idle state with no change to the array.
- R12: Writes that arrive while `busy` is high are ignored, including complete command sequences.
- R13: If `permit` is low on the final write of a program or erase sequence, `busy` stays low and the array is unchanged.
- R14: `rdata` is updated on the clock edge that samples `rd_en` high. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe for the current cycle |
| rd_en | input | 1 | Bus read strobe for the current cycle |
| addr | input | 16 | Bus byte address; low ARR_AW bits index the array |
| wdata | input | 8 | Write data / command byte |
| permit | input | 1 | External protection verdict, sampled on the final write of a sequence |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | Embedded operation in progress |

## Verification
Results have different latencies. A read answers one edge after `rd_en` is sampled. `busy` rises on the edge that accepts the last command write. Array contents change on the edge where `busy` falls, which is exactly T cycles later. The bench keeps a behavioural model that is updated on each rising edge in step with the design. It compares `rdata` and `busy` one nanosecond after every edge, so each value is judged in the cycle it becomes due. Directed checks add literal expectations: busy-cycle counts measured at falling edges, status bits read during operations, and array values read after completion.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int BUS_AW = 16;

    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [BUS_AW-1:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0] UNLOCK_BYTE_A = 8'hAA;
    localparam logic [7:0] UNLOCK_BYTE_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SET = 8'h80;
    localparam logic [7:0] CMD_CHIP      = 8'h10;
    localparam logic [7:0] CMD_SECTOR    = 8'h30;
    localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
    localparam logic [7:0] CMD_EXIT      = 8'hF0;
    localparam logic [7:0] ID_MAKER      = 8'hDA;
    localparam logic [7:0] ID_DEVICE     = 8'hB0;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PDATA,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3
    } seq_state_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } op_cmd_t;

    function automatic logic bus_hit(
        input logic [BUS_AW-1:0] a,
        input logic [7:0]        d,
        input logic [BUS_AW-1:0] ea,
        input logic [7:0]        ed
    );
        return (a == ea) && (d == ed);
    endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              permit,
    output logic              start,
    output op_cmd_t           cmd,
    output logic              id_mode
);

    seq_state_e state_q, state_d;
    logic       id_d;

    always_comb begin
        state_d  = state_q;
        id_d     = id_mode;
        start    = 1'b0;
        cmd.kind = OP_PROG;
        cmd.data = wdata;
        if (wr_en && !busy) begin
            state_d = SQ_IDLE;
            if (state_q != SQ_PDATA && wdata == CMD_EXIT) begin
                id_d = 1'b0;
            end else begin
                case (state_q)
                    SQ_IDLE: begin
                        if (bus_hit(addr, wdata, UNLOCK_ADDR_A, UNLOCK_BYTE_A))
                            state_d = SQ_UNL1;
                    end
                    SQ_UNL1: begin
                        if (bus_hit(addr, wdata, UNLOCK_ADDR_B, UNLOCK_BYTE_B))
                            state_d = SQ_UNL2;
                    end
                    SQ_UNL2: begin
                        if (addr == UNLOCK_ADDR_A) begin
                            if (wdata == CMD_PROGRAM)        state_d = SQ_PDATA;
                            else if (wdata == CMD_ERASE_SET) state_d = SQ_ERA1;
                            else if (wdata == CMD_ID_ENTER)  id_d    = 1'b1;
                        end
                    end
                    SQ_PDATA: begin
                        if (permit) begin
                            start    = 1'b1;
                            cmd.kind = OP_PROG;
                            id_d     = 1'b0;
                        end
                    end
                    SQ_ERA1: begin
                        if (bus_hit(addr, wdata, UNLOCK_ADDR_A, UNLOCK_BYTE_A))
                            state_d = SQ_ERA2;
                    end
                    SQ_ERA2: begin
                        if (bus_hit(addr, wdata, UNLOCK_ADDR_B, UNLOCK_BYTE_B))
                            state_d = SQ_ERA3;
                    end
                    SQ_ERA3: begin
                        if (permit && bus_hit(addr, wdata, UNLOCK_ADDR_A, CMD_CHIP)) begin
                            start    = 1'b1;
                            cmd.kind = OP_CHIP;
                            id_d     = 1'b0;
                        end else if (permit && wdata == CMD_SECTOR) begin
                            start    = 1'b1;
                            cmd.kind = OP_SECT;
                            id_d     = 1'b0;
                        end
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            state_q <= state_d;
            id_mode <= id_d;
        end
    end

endmodule

// File: rtl/fcs_optimer.sv
module fcs_optimer
    import fcs_pkg::*;
#(
    parameter int ARR_AW = 10,
    parameter int T_PROG = 6,
    parameter int T_SECT = 20,
    parameter int T_CHIP = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_cmd_t           cmd_in,
    input  logic [ARR_AW-1:0] idx_in,
    output logic              busy,
    output logic              done,
    output op_cmd_t           cur_cmd,
    output logic [ARR_AW-1:0] cur_idx
);

    localparam int T_BIG = (T_SECT > T_CHIP) ? T_SECT : T_CHIP;
    localparam int T_MAX = (T_PROG > T_BIG) ? T_PROG : T_BIG;
    localparam int CW    = $clog2(T_MAX + 1);

    logic [CW-1:0] left_q;

    function automatic logic [CW-1:0] op_len(input op_kind_e k);
        case (k)
            OP_SECT: return CW'(T_SECT);
            OP_CHIP: return CW'(T_CHIP);
            default: return CW'(T_PROG);
        endcase
    endfunction

    assign done = busy && (left_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            left_q        <= '0;
            cur_cmd.kind  <= OP_PROG;
            cur_cmd.data  <= 8'h00;
            cur_idx       <= '0;
        end else if (busy) begin
            left_q <= left_q - CW'(1);
            if (done) busy <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            left_q  <= op_len(cmd_in.kind);
            cur_cmd <= cmd_in;
            cur_idx <= idx_in;
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int ARR_AW = 10,
    parameter int SEC_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  op_cmd_t           op,
    input  logic [ARR_AW-1:0] op_idx,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [7:0]        rd_byte
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem [DEPTH];

    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done) begin
            case (op.kind)
                OP_PROG: mem[op_idx] <= mem[op_idx] & op.data;
                OP_SECT: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (i[ARR_AW-1:SEC_AW] == op_idx[ARR_AW-1:SEC_AW])
                            mem[i] <= 8'hFF;
                    end
                end
                OP_CHIP: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fcs_readout.sv
module fcs_readout
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic              busy,
    input  op_kind_e          op_kind,
    input  logic              op_bit7,
    input  logic              id_mode,
    input  logic [7:0]        arr_byte,
    output logic [7:0]        rdata
);

    logic toggle_q;
    logic poll_bit;
    logic [7:0] id_byte;

    assign poll_bit = (op_kind == OP_PROG) ? ~op_bit7 : 1'b0;

    always_comb begin
        if (addr == 16'h0000)      id_byte = ID_MAKER;
        else if (addr == 16'h0001) id_byte = ID_DEVICE;
        else                       id_byte = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= 8'h00;
            toggle_q <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata    <= {poll_bit, toggle_q, 6'b000000};
                toggle_q <= ~toggle_q;
            end else if (id_mode) begin
                rdata <= id_byte;
            end else begin
                rdata <= arr_byte;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ARR_AW = 10,
    parameter int SEC_AW = 8,
    parameter int T_PROG = 6,
    parameter int T_SECT = 20,
    parameter int T_CHIP = 30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        permit,
    output logic [7:0]  rdata,
    output logic        busy
);

    logic              start;
    logic              done;
    logic              id_mode;
    op_cmd_t           new_cmd;
    op_cmd_t           cur_cmd;
    logic [ARR_AW-1:0] cur_idx;
    logic [7:0]        arr_byte;

    fcs_decoder u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .busy    (busy),
        .permit  (permit),
        .start   (start),
        .cmd     (new_cmd),
        .id_mode (id_mode)
    );

    fcs_optimer #(
        .ARR_AW (ARR_AW),
        .T_PROG (T_PROG),
        .T_SECT (T_SECT),
        .T_CHIP (T_CHIP)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd_in  (new_cmd),
        .idx_in  (addr[ARR_AW-1:0]),
        .busy    (busy),
        .done    (done),
        .cur_cmd (cur_cmd),
        .cur_idx (cur_idx)
    );

    fcs_array #(
        .ARR_AW (ARR_AW),
        .SEC_AW (SEC_AW)
    ) u_arr (
        .clk     (clk),
        .rst     (rst),
        .done    (done),
        .op      (cur_cmd),
        .op_idx  (cur_idx),
        .rd_idx  (addr[ARR_AW-1:0]),
        .rd_byte (arr_byte)
    );

    fcs_readout u_rdo (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .busy     (busy),
        .op_kind  (cur_cmd.kind),
        .op_bit7  (cur_cmd.data[7]),
        .id_mode  (id_mode),
        .arr_byte (arr_byte),
        .rdata    (rdata)
    );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        busy,
    input logic        start,
    input logic        done,
    input logic        id_mode,
    input logic [15:0] addr,
    input logic [7:0]  rdata,
    input op_kind_e    cur_kind
);

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);  // R12

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);  // R9

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);  // R9

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && cur_kind != OP_PROG) |=> (!rdata[7] && rdata[5:0] == 6'd0));  // R7

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) ##1 (rd_en && busy) |=> (rdata[6] != $past(rdata[6])));  // R8

    AST_ID_MAKER_CODE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !busy && id_mode && addr == 16'h0000) |=> (rdata == ID_MAKER));  // R10

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));  // R14

endmodule

bind flash_cmd_seq fcs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .busy     (busy),
    .start    (start),
    .done     (done),
    .id_mode  (id_mode),
    .addr     (addr),
    .rdata    (rdata),
    .cur_kind (cur_cmd.kind)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

    localparam int ARR_AW = 10;
    localparam int SEC_AW = 8;
    localparam int TP     = 6;
    localparam int TS     = 20;
    localparam int TC     = 30;
    localparam int DEPTH  = 1 << ARR_AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        permit = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        busy;

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .ARR_AW (ARR_AW), .SEC_AW (SEC_AW),
        .T_PROG (TP), .T_SECT (TS), .T_CHIP (TC)
    ) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .permit (permit),
        .rdata (rdata), .busy (busy)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [7:0]  m_mem [DEPTH];
    logic [23:0] m_q[$];
    bit          m_id, m_busy, m_tgl, was_busy;
    int          m_left, m_kind;
    logic [15:0] m_a;
    logic [7:0]  m_d, m_rd;

    task automatic m_launch(input int kind);
        m_busy = 1'b1;
        m_kind = kind;
        m_left = (kind == 0) ? TP : (kind == 1) ? TS : TC;
        m_a    = addr;
        m_d    = wdata;
        m_id   = 1'b0;
    endtask

    task automatic m_write();
        int n;
        bit prog_data;
        prog_data = (m_q.size() == 3) && (m_q[2][7:0] == 8'hA0);
        if (!prog_data && wdata == 8'hF0) begin
            m_q.delete();
            m_id = 1'b0;
            return;
        end
        m_q.push_back({addr, wdata});
        n = m_q.size();
        case (n)
            1: if (m_q[0] != {16'h5555, 8'hAA}) m_q.delete();
            2: if (m_q[1] != {16'h2AAA, 8'h55}) m_q.delete();
            3: begin
                if (m_q[2][23:8] != 16'h5555 ||
                    !(m_q[2][7:0] == 8'hA0 || m_q[2][7:0] == 8'h80)) begin
                    if (m_q[2] == {16'h5555, 8'h90}) m_id = 1'b1;
                    m_q.delete();
                end
            end
            4: begin
                if (m_q[2][7:0] == 8'hA0) begin
                    if (permit) m_launch(0);
                    m_q.delete();
                end else if (m_q[3] != {16'h5555, 8'hAA}) m_q.delete();
            end
            5: if (m_q[4] != {16'h2AAA, 8'h55}) m_q.delete();
            default: begin
                if (permit && m_q[5] == {16'h5555, 8'h10}) m_launch(2);
                else if (permit && m_q[5][7:0] == 8'h30) m_launch(1);
                m_q.delete();
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_q.delete();
            m_id = 0; m_busy = 0; m_tgl = 0; m_left = 0; m_kind = 0;
            m_a = 0; m_d = 0; m_rd = 8'h00;
        end else begin
            was_busy = m_busy;
            if (rd_en) begin
                if (m_busy) begin
                    m_rd  = {(m_kind == 0) ? ~m_d[7] : 1'b0, m_tgl, 6'b0};
                    m_tgl = !m_tgl;
                end else if (m_id) begin
                    m_rd = (addr == 16'h0) ? 8'hDA : (addr == 16'h1) ? 8'hB0 : 8'h00;
                end else begin
                    m_rd = m_mem[addr[ARR_AW-1:0]];
                end
            end
            if (was_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    if (m_kind == 0) begin
                        m_mem[m_a[ARR_AW-1:0]] = m_mem[m_a[ARR_AW-1:0]] & m_d;
                    end else begin
                        for (int i = 0; i < DEPTH; i++)
                            if (m_kind == 2 || (i >> SEC_AW) == (int'(m_a[ARR_AW-1:0]) >> SEC_AW))
                                m_mem[i] = 8'hFF;
                    end
                end
            end
            if (wr_en && !was_busy) m_write();
        end
    end

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        n_vec++;
        if (rdata !== m_rd || busy !== m_busy) begin
            n_bad++;
            $display("FAIL %s cycle compare: rdata=%h busy=%b expected rdata=%h busy=%b",
                     cur_req, rdata, busy, m_rd, m_busy);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic prefix();
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        prefix();
        wr(16'h5555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_setup();
        prefix();
        wr(16'h5555, 8'h80);
        prefix();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rdata after reset", int'(rdata), 8'h00);
        rd(16'h03FF, v); check("R1 erased top byte", v, 8'hFF);

        cur_req = "R3";
        prog(16'h0005, 8'hA5);
        check("R9 busy rises", int'(busy), 1);
        busy_len(n); check("R9 program length", n, TP);
        rd(16'h0005, v); check("R3 first program", v, 8'hA5);

        cur_req = "R6";
        prog(16'h0005, 8'h3C);
        rd(16'h0005, v); check("R6 poll bit complement", int'(v[7]), 1);
        rd(16'h0005, v2); check("R8 toggle flips", int'(v2[6]), int'(!v[6]));
        busy_len(n);
        rd(16'h0005, v); check("R3 bits only cleared", v, 8'h24);
        check("R6 true data after", int'(v[7]), 0);

        cur_req = "R14";
        @(negedge clk); @(negedge clk);
        check("R14 rdata holds", int'(rdata), 8'h24);

        cur_req = "R4";
        prog(16'h0105, 8'h11); busy_len(n);
        erase_setup(); wr(16'h0042, 8'h30);
        rd(16'h0005, v); check("R7 erase poll low", int'(v[7]), 0);
        check("R7 low bits zero", int'(v[5:0]), 0);
        rd(16'h0005, v2); check("R8 toggle during erase", int'(v2[6]), int'(!v[6]));
        busy_len(n); check("R9 sector length", n, TS - 2);
        rd(16'h0005, v); check("R4 sector erased", v, 8'hFF);
        rd(16'h0105, v); check("R4 other sector kept", v, 8'h11);

        cur_req = "R11";
        wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0020, 8'h00);
        check("R11 no op after broken prefix", int'(busy), 0);
        rd(16'h0020, v); check("R11 byte unchanged", v, 8'hFF);
        erase_setup(); wr(16'h5555, 8'h20);
        check("R11 broken erase", int'(busy), 0);
        rd(16'h0105, v); check("R11 array intact", v, 8'h11);

        cur_req = "R2";
        prefix(); wr(16'h5556, 8'h90);
        rd(16'h0000, v); check("R2 misplaced command", v, 8'hFF);

        cur_req = "R12";
        prog(16'h0030, 8'h0F);
        prog(16'h0031, 8'h00);
        busy_len(n);
        rd(16'h0031, v); check("R12 write during busy ignored", v, 8'hFF);
        rd(16'h0030, v); check("R12 first op done", v, 8'h0F);

        cur_req = "R13";
        permit = 1'b0;
        prog(16'h0040, 8'h00);
        check("R13 no start", int'(busy), 0);
        erase_setup(); wr(16'h5555, 8'h10);
        check("R13 no chip erase", int'(busy), 0);
        permit = 1'b1;
        rd(16'h0040, v); check("R13 byte kept", v, 8'hFF);

        cur_req = "R10";
        prefix(); wr(16'h5555, 8'h90);
        rd(16'h0000, v); check("R10 maker code", v, 8'hDA);
        rd(16'h0001, v); check("R10 device code", v, 8'hB0);
        rd(16'h0002, v); check("R10 other offset", v, 8'h00);
        wr(16'h1234, 8'hF0);
        rd(16'h0030, v); check("R10 single exit", v, 8'h0F);
        prefix(); wr(16'h5555, 8'h90);
        prefix(); wr(16'h5555, 8'hF0);
        rd(16'h0001, v); check("R10 prefixed exit", v, 8'hFF);

        cur_req = "R5";
        erase_setup(); wr(16'h5555, 8'h10);
        busy_len(n); check("R9 chip length", n, TC);
        rd(16'h0030, v); check("R5 chip erased low", v, 8'hFF);
        rd(16'h0105, v); check("R5 chip erased high", v, 8'hFF);

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule